// File: doc/BRIEF.md
# Flash Readout Protection Controller

This block guards a small modelled flash array with a protection level that is held in an 8-bit option byte. Two code values of that byte are special. The value 0xAA opens the array and the value 0xCC locks it permanently. Any other value gives the intermediate protected level. On every flash request the controller looks at the level, the boot source and whether a debugger is attached. It then grants the access or answers with an error. A denied read gets a bus error, and a denied erase or program gets an error response.

Option-byte writes change the level. Moving from the protected level back to the open level first wipes the whole user array. The wipe is a sweep that writes all ones into every word, one word per cycle. The new byte is stored only after the sweep ends, and the busy flag stays high for the whole sweep. Raising the level never wipes anything. At the locked level the option byte refuses every change, and the debug-disable output is held high.

All responses are registered and appear in the cycle after the request.

Top module: `rdp_ctrl`

## Requirements
- R1: The level output `prot_level` is 0 when the stored byte is 0xAA, 2 when it is 0xCC, and 1 for every other byte value.
- R2: After reset the stored byte equals parameter `OB_RESET` (default 0xFF, so level 1). The array holds all ones, and `busy`, `acc_grant`, `acc_buserr`, `acc_err` and `ob_err` are all low.
- R3: At level 0, a read (`acc_op`=0), an erase (`acc_op`=1) or a program (`acc_op`=2) is granted whatever the boot source and debug flag are. `acc_grant` goes high in the cycle after the request.
- R4: At level 1 or 2, a read is denied when `dbg_conn`=1 or when `boot_src`!=0. Here `boot_src` 0 is flash, 1 is RAM and 2 is the system loader. A denied read gives `acc_buserr`=1 and `acc_grant`=0 in the next cycle, and the three response flags are never high together.
- R5: At level 1 or 2, an erase or program denied under the conditions of R4 gives `acc_err`=1 in the next cycle and leaves the array unchanged.
- R6: With `boot_src`=0 and `dbg_conn`=0, accesses are granted at every level. A read returns the stored word on `acc_rdata`, a program stores `acc_wdata`, and an erase sets the word to all ones.
- R7: An option-byte write that moves the level from 1 to 0 raises `busy` in the next cycle. `busy` stays high for exactly `DEPTH` cycles while every word is set to all ones. The level stays 1 throughout the sweep and becomes 0 when `busy` falls.
- R8: Any other option-byte write below level 2 is stored in the next cycle without raising `busy`, and the array is kept. This covers 0 to 1, 0 to 2, 1 to 2, and writes within the same level.
- R9: At level 2, every option-byte write is refused. `ob_err` pulses in the next cycle and the level stays 2.
- R10: `dbg_disable` is high exactly when the level is 2.
- R11: While `busy` is high, an access request gets no grant and no error and changes nothing. An option-byte write is refused with an `ob_err` pulse and does not alter the pending byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_src | input | 2 | Boot source: 0 flash, 1 RAM, 2 or 3 system loader |
| dbg_conn | input | 1 | Debugger attached |
| acc_req | input | 1 | Flash access request, one cycle |
| acc_op | input | 2 | 0 read, 1 erase word, 2 program word (3 acts as program) |
| acc_addr | input | AW | Word address |
| acc_wdata | input | DW | Program data |
| ob_wr_req | input | 1 | Option-byte write request, one cycle |
| ob_wr_data | input | 8 | New option-byte value |
| acc_grant | output | 1 | Access carried out |
| acc_rdata | output | DW | Read data, valid with a granted read, else zero |
| acc_buserr | output | 1 | Denied read |
| acc_err | output | 1 | Denied erase or program |
| ob_err | output | 1 | Refused option-byte write |
| dbg_disable | output | 1 | Debug and trace ports off |
| busy | output | 1 | Mass-erase sweep running |
| prot_level | output | 2 | Current protection level 0, 1 or 2 |

## Verification
The assertions assume that requests are single-cycle pulses sampled at rising edges. They also assume that `boot_src` codes 2 and 3 mean the same non-flash boot, and that nothing outside the block alters the stored byte. The stimulus drives every input on falling edges and keeps `acc_op` within 0 to 2. Random option-byte values never include 0xCC, so the irreversible lock is entered only by the final directed step. One directed probe issues both a program and an option-byte write in the middle of a sweep, to exercise the stall rules.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN = 2'd0,
        LVL_PROT = 2'd1,
        LVL_LOCK = 2'd2
    } lvl_e;

    localparam logic [7:0] OB_OPEN_CODE = 8'hAA;
    localparam logic [7:0] OB_LOCK_CODE = 8'hCC;

    localparam logic [1:0] BOOT_FLASH = 2'd0;

    localparam logic [1:0] OP_READ  = 2'd0;
    localparam logic [1:0] OP_ERASE = 2'd1;

    function automatic lvl_e ob_to_level(input logic [7:0] code);
        if (code == OB_OPEN_CODE)      return LVL_OPEN;
        else if (code == OB_LOCK_CODE) return LVL_LOCK;
        else                           return LVL_PROT;
    endfunction

endpackage

// File: rtl/rdp_gate.sv
module rdp_gate
    import rdp_pkg::*;
(
    input  lvl_e       level,
    input  logic [1:0] boot_src,
    input  logic       dbg_conn,
    input  logic       req,
    input  logic [1:0] op,
    input  logic       stall,
    output logic       grant,
    output logic       buserr,
    output logic       err
);
    logic path_ok;
    logic live;
    logic is_read;

    always_comb begin
        path_ok = (level == LVL_OPEN) || ((boot_src == BOOT_FLASH) && !dbg_conn);
        live    = req && !stall;
        is_read = (op == OP_READ);
        grant   = live && path_ok;
        buserr  = live && !path_ok && is_read;
        err     = live && !path_ok && !is_read;
    end

endmodule

// File: rtl/rdp_ob_ctrl.sv
module rdp_ob_ctrl
    import rdp_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter logic [7:0] OB_RESET = 8'hFF,
    parameter int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [7:0]    wr_data,
    output lvl_e          level,
    output logic          busy,
    output logic          wr_err,
    output logic          sweep_we,
    output logic [AW-1:0] sweep_addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [7:0]    ob;
        logic [7:0]    pend;
        logic          busy;
        logic [AW-1:0] cnt;
        logic          err;
    } ob_state_t;

    ob_state_t s_d, s_q;
    lvl_e      cur_lvl;

    always_comb begin
        cur_lvl = ob_to_level(s_q.ob);
        s_d     = s_q;
        s_d.err = 1'b0;
        if (s_q.busy) begin
            if (wr_req) s_d.err = 1'b1;
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.ob   = s_q.pend;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (wr_req) begin
            if (cur_lvl == LVL_LOCK) begin
                s_d.err = 1'b1;
            end else if ((cur_lvl == LVL_PROT) && (ob_to_level(wr_data) == LVL_OPEN)) begin
                s_d.busy = 1'b1;
                s_d.pend = wr_data;
                s_d.cnt  = '0;
            end else begin
                s_d.ob = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ob: OB_RESET, pend: OB_RESET, busy: 1'b0, cnt: '0, err: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign level      = cur_lvl;
    assign busy       = s_q.busy;
    assign wr_err     = s_q.err;
    assign sweep_we   = s_q.busy;
    assign sweep_addr = s_q.cnt;

endmodule

// File: rtl/rdp_array.sv
module rdp_array #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(waddr) < DEPTH)) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '1};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem_q[raddr] : '1;

endmodule

// File: rtl/rdp_ctrl.sv
module rdp_ctrl
    import rdp_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter int         DW       = 32,
    parameter logic [7:0] OB_RESET = 8'hFF,
    parameter int         AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    boot_src,
    input  logic          dbg_conn,
    input  logic          acc_req,
    input  logic [1:0]    acc_op,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          ob_wr_req,
    input  logic [7:0]    ob_wr_data,
    output logic          acc_grant,
    output logic [DW-1:0] acc_rdata,
    output logic          acc_buserr,
    output logic          acc_err,
    output logic          ob_err,
    output logic          dbg_disable,
    output logic          busy,
    output logic [1:0]    prot_level
);
    typedef struct packed {
        logic          grant;
        logic          buserr;
        logic          err;
        logic [DW-1:0] rdata;
    } rsp_t;

    rsp_t          rsp_d, rsp_q;
    lvl_e          level;
    logic          sweep_busy;
    logic          sweep_we;
    logic [AW-1:0] sweep_addr;
    logic          g_grant, g_buserr, g_err;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    rdp_ob_ctrl #(.DEPTH(DEPTH), .OB_RESET(OB_RESET), .AW(AW)) u_ob (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (ob_wr_req),
        .wr_data    (ob_wr_data),
        .level      (level),
        .busy       (sweep_busy),
        .wr_err     (ob_err),
        .sweep_we   (sweep_we),
        .sweep_addr (sweep_addr)
    );

    rdp_gate u_gate (
        .level    (level),
        .boot_src (boot_src),
        .dbg_conn (dbg_conn),
        .req      (acc_req),
        .op       (acc_op),
        .stall    (sweep_busy),
        .grant    (g_grant),
        .buserr   (g_buserr),
        .err      (g_err)
    );

    always_comb begin
        mem_we    = sweep_we || (g_grant && (acc_op != OP_READ));
        mem_waddr = sweep_we ? sweep_addr : acc_addr;
        if (sweep_we || (acc_op == OP_ERASE)) mem_wdata = '1;
        else                                  mem_wdata = acc_wdata;
    end

    rdp_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (acc_addr),
        .rdata (mem_rdata)
    );

    always_comb begin
        rsp_d.grant  = g_grant;
        rsp_d.buserr = g_buserr;
        rsp_d.err    = g_err;
        rsp_d.rdata  = (g_grant && (acc_op == OP_READ)) ? mem_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign acc_grant   = rsp_q.grant;
    assign acc_buserr  = rsp_q.buserr;
    assign acc_err     = rsp_q.err;
    assign acc_rdata   = rsp_q.rdata;
    assign busy        = sweep_busy;
    assign prot_level  = level;
    assign dbg_disable = (level == LVL_LOCK);

endmodule

// File: rtl/rdp_ctrl_chk.sv
module rdp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] boot_src,
    input logic       dbg_conn,
    input logic       acc_req,
    input logic [1:0] acc_op,
    input logic       ob_wr_req,
    input logic [7:0] ob_wr_data,
    input logic       acc_grant,
    input logic       acc_buserr,
    input logic       acc_err,
    input logic       ob_err,
    input logic       dbg_disable,
    input logic       busy,
    input logic [1:0] prot_level
);
    AST_OPEN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !busy && prot_level == 2'd0 |=> acc_grant); // R3

    AST_DENY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !busy && acc_op == 2'd0 && prot_level != 2'd0 && (dbg_conn || boot_src != 2'd0)
        |=> acc_buserr && !acc_grant); // R4

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({acc_grant, acc_buserr, acc_err}) <= 1); // R4

    AST_DENY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req && !busy && acc_op != 2'd0 && prot_level != 2'd0 && (dbg_conn || boot_src != 2'd0)
        |=> acc_err && !acc_grant); // R5

    AST_LOWER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ob_wr_req && prot_level == 2'd1 && ob_wr_data == 8'hAA |=> busy); // R7

    AST_SWEEP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> prot_level == 2'd1); // R7

    AST_RAISE_NO_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && ob_wr_req && prot_level == 2'd0 |=> !busy); // R8

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prot_level == 2'd2 |=> prot_level == 2'd2); // R9

    AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_level == 2'd2 && ob_wr_req |=> ob_err); // R9

    AST_DBG_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_disable) |-> $past(ob_wr_req)); // R10

    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && acc_req |=> !acc_grant && !acc_buserr && !acc_err); // R11

    AST_BUSY_OB_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ob_wr_req |=> ob_err); // R11

endmodule

bind rdp_ctrl rdp_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boot_src    (boot_src),
    .dbg_conn    (dbg_conn),
    .acc_req     (acc_req),
    .acc_op      (acc_op),
    .ob_wr_req   (ob_wr_req),
    .ob_wr_data  (ob_wr_data),
    .acc_grant   (acc_grant),
    .acc_buserr  (acc_buserr),
    .acc_err     (acc_err),
    .ob_err      (ob_err),
    .dbg_disable (dbg_disable),
    .busy        (busy),
    .prot_level  (prot_level)
);

// File: tb/rdp_ctrl_tb.sv
module rdp_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int DW         = 32;
    localparam int AW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    boot_src = '0;
    logic          dbg_conn = 1'b0;
    logic          acc_req = 1'b0;
    logic [1:0]    acc_op = '0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic          ob_wr_req = 1'b0;
    logic [7:0]    ob_wr_data = '0;
    logic          acc_grant, acc_buserr, acc_err, ob_err, dbg_disable, busy;
    logic [DW-1:0] acc_rdata;
    logic [1:0]    prot_level;

    int checks = 0;
    int errors = 0;

    logic [7:0]    ob_m;
    logic [DW-1:0] mem_m [DEPTH];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rdp_ctrl #(.DEPTH(DEPTH), .DW(DW), .OB_RESET(8'hFF)) u_dut (
        .clk(clk), .rst_n(rst_n), .boot_src(boot_src), .dbg_conn(dbg_conn),
        .acc_req(acc_req), .acc_op(acc_op), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .ob_wr_req(ob_wr_req), .ob_wr_data(ob_wr_data),
        .acc_grant(acc_grant), .acc_rdata(acc_rdata), .acc_buserr(acc_buserr),
        .acc_err(acc_err), .ob_err(ob_err), .dbg_disable(dbg_disable),
        .busy(busy), .prot_level(prot_level)
    );

    function automatic logic [1:0] lvl_of(input logic [7:0] b);
        if (b == 8'hAA) return 2'd0;
        if (b == 8'hCC) return 2'd2;
        return 2'd1;
    endfunction

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] op, input int addr, input logic [DW-1:0] wd,
                       input logic [1:0] bs, input logic dbg);
        logic ok;
        string tg;
        @(negedge clk);
        acc_req = 1'b1; acc_op = op; acc_addr = AW'(addr); acc_wdata = wd;
        boot_src = bs; dbg_conn = dbg;
        @(negedge clk);
        acc_req = 1'b0;
        ok = (lvl_of(ob_m) == 2'd0) || (bs == 2'd0 && !dbg);
        if (lvl_of(ob_m) == 2'd0) tg = "R3";
        else if (ok)              tg = "R6";
        else if (op == 2'd0)      tg = "R4";
        else                      tg = "R5";
        chk(tg, acc_grant, ok);
        chk(tg, acc_buserr, !ok && op == 2'd0);
        chk(tg, acc_err, !ok && op != 2'd0);
        if (ok && op == 2'd0) chk(tg, acc_rdata, mem_m[addr]);
        if (ok && op == 2'd1) mem_m[addr] = '1;
        if (ok && op == 2'd2) mem_m[addr] = wd;
    endtask

    task automatic obw(input logic [7:0] d, input logic probe);
        logic [1:0] cur;
        int n;
        cur = lvl_of(ob_m);
        @(negedge clk);
        ob_wr_req = 1'b1; ob_wr_data = d;
        @(negedge clk);
        ob_wr_req = 1'b0;
        if (cur == 2'd2) begin
            chk("R9", ob_err, 1'b1);
            chk("R9", prot_level, 2'd2);
            chk("R9", busy, 1'b0);
        end else if (cur == 2'd1 && lvl_of(d) == 2'd0) begin
            chk("R7", busy, 1'b1);
            chk("R7", prot_level, 2'd1);
            n = busy ? 1 : 0;
            while (busy && n < DEPTH + 4) begin
                if (probe && n == 3) begin
                    acc_req = 1'b1; acc_op = 2'd2; acc_addr = '0; acc_wdata = 32'h0;
                    boot_src = 2'd0; dbg_conn = 1'b0;
                    ob_wr_req = 1'b1; ob_wr_data = 8'hCC;
                end
                @(negedge clk);
                if (probe && n == 3) begin
                    acc_req = 1'b0; ob_wr_req = 1'b0;
                    chk("R11", {acc_grant, acc_err, acc_buserr}, 3'b000);
                    chk("R11", ob_err, 1'b1);
                end
                if (busy) n++;
            end
            chk("R7", n, DEPTH);
            for (int i = 0; i < DEPTH; i++) mem_m[i] = '1;
            ob_m = d;
            chk("R7", prot_level, 2'd0);
        end else begin
            chk("R8", busy, 1'b0);
            chk("R8", ob_err, 1'b0);
            ob_m = d;
            chk("R1", prot_level, lvl_of(d));
        end
        chk("R10", dbg_disable, lvl_of(ob_m) == 2'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        ob_m = 8'hFF;
        for (int i = 0; i < DEPTH; i++) mem_m[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk("R2", prot_level, 2'd1);
        chk("R2", {busy, acc_grant, acc_buserr, acc_err, ob_err}, 5'b0);
        chk("R10", dbg_disable, 1'b0);
        acc(2'd0, 7, '0, 2'd0, 1'b0);                 // R2 erased contents
        // R6: user code from flash
        acc(2'd2, 3, 32'h1234_5678, 2'd0, 1'b0);
        acc(2'd0, 3, '0, 2'd0, 1'b0);
        // R4, R5: denied paths at level 1
        acc(2'd0, 3, '0, 2'd0, 1'b1);
        acc(2'd2, 3, 32'hDEAD_0000, 2'd1, 1'b0);
        acc(2'd1, 3, '0, 2'd2, 1'b0);
        acc(2'd0, 3, '0, 2'd0, 1'b0);                 // R5 word kept
        acc(2'd1, 4, '0, 2'd0, 1'b0);
        // R8, R1: stay at level 1 with another code
        obw(8'h5A, 1'b0);
        acc(2'd0, 3, '0, 2'd0, 1'b0);
        // R7, R11: lowering with a probe mid sweep
        obw(8'hAA, 1'b1);
        acc(2'd0, 0, '0, 2'd0, 1'b0);                 // R11 probe write lost
        acc(2'd0, 3, '0, 2'd0, 1'b0);
        // R3: open level, every path
        acc(2'd2, 5, 32'hCAFE_F00D, 2'd1, 1'b1);
        acc(2'd0, 5, '0, 2'd2, 1'b0);
        acc(2'd1, 5, '0, 2'd0, 1'b1);
        acc(2'd2, 6, 32'h0BAD_BEEF, 2'd2, 1'b1);
        // R8: raise 0 to 1, data kept
        obw(8'h00, 1'b0);
        acc(2'd0, 6, '0, 2'd0, 1'b0);
        // random mix
        for (int it = 0; it < 400; it++) begin
            if ($urandom_range(0, 99) < 12) begin
                logic [7:0] b;
                b = 8'($urandom);
                if ($urandom_range(0, 2) == 0) b = 8'hAA;
                if (b == 8'hCC) b = 8'h33;
                obw(b, 1'b0);
            end else begin
                acc(2'($urandom_range(0, 2)), $urandom_range(0, DEPTH - 1), $urandom,
                    2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
            end
        end
        // R8, R10: raise to lock
        acc(2'd2, 9, 32'h5555_AAAA, 2'd0, 1'b0);
        obw(8'hCC, 1'b0);
        chk("R10", dbg_disable, 1'b1);
        // R9: lock is permanent
        obw(8'hAA, 1'b0);
        obw(8'h12, 1'b0);
        acc(2'd0, 9, '0, 2'd0, 1'b0);                 // R6 at level 2
        acc(2'd0, 9, '0, 2'd0, 1'b1);                 // R4 at level 2
        acc(2'd2, 9, 32'h0, 2'd1, 1'b0);              // R5 at level 2
        acc(2'd0, 9, '0, 2'd0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule